// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Sequencer

This block is a clocked controller for a dual simultaneous-sampling converter with a 14-bit parallel read bus. Each frame takes up to two conversions, pair A and then pair B. For each pair the block drives the channel-select line and pulses the active-low start strobe. It then waits for the converter's busy line to drop and reads both held results in one chip-select window that holds two read pulses. Each captured word leaves the block as a one-cycle result pulse with a tag that names the pair and the input. A one-cycle frame-done pulse marks the end of the frame.

Every converter timing rule is counted in clock cycles. Each count comes from the `CYC_PER_US` parameter, rounded up. The rules covered are:
- the settling time of the channel-select line before a conversion starts;
- the quiet window after a read;
- the conversion limit, which sets the busy timeout;
- in auto-sleep mode, the wake-up delay, whose length depends on the reference choice.

The operating mode, the reference choice and the pair enables are taken as inputs and latched when a frame request is accepted.

The state machine has seven states:
- `S_IDLE` accepts a request → `S_RISE`.
- `S_RISE` raises the strobe → `S_SETUP`.
- `S_SETUP` drives channel select and waits for the gap or wake-up delay → `S_FALL`.
- `S_FALL` holds the strobe low → `S_CONV`.
- `S_CONV` waits for busy low → `S_RD_LO`, or on timeout → `S_IDLE`.
- `S_RD_LO` → `S_RD_HI`, which goes back to `S_RD_LO` for the second read.
- After the second read, `S_RD_HI` goes to `S_RISE` for pair B, or to `S_IDLE` with frame done.

Top module: `adc_frame_seq`

## Requirements
- R1: After reset, the strobe, chip-select and read lines are high, channel select is low, and result-valid, frame-done and the error flag are low.
- R2: The block converts enabled pairs in order: A (channel select 0) first, then B (channel select 1). It skips a disabled pair. A request with both enables low starts nothing.
- R3: Each falling edge of the strobe comes at least ceil(0.5 µs) cycles after the last change of channel select, and at least ceil(0.4 µs) cycles after chip-select last went high. Channel select changes only while the strobe is high and was high in the previous cycle.
- R4: A read pulse starts only when busy is low. No read pulse is ever low while busy is high.
- R5: Each chip-select low window holds exactly two read pulses. Each read pulse stays low at least `RD_LO_CYC` cycles, and the gap between the two pulses is at least `RD_HI_CYC` cycles.
- R6: Data is captured on the cycle in which the read line rises. The block then pulses result-valid for one cycle with that data and a 2-bit tag: bit 1 is the pair (0 = A, 1 = B) and bit 0 is the input (0 = first read, 1 = second read).
- R7: In normal mode, the strobe goes low for `START_LO_CYC` cycles and then returns high. It stays high between frames.
- R8: In auto-sleep mode, the strobe stays low after the conversion. It rises at the start of the next pair. It falls no sooner than ceil(4.8 µs) cycles after that rise with an external reference, or ceil(5000 µs) cycles with the internal reference.
- R9: The error flag is set when busy is still high 2·ceil(5.2 µs) cycles after conversion starts. In that case the block returns to idle with no read and no frame-done. The next accepted request clears the flag.
- R10: Frame-done is a one-cycle pulse that follows the last read of the frame.
- R11: A request that arrives while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_req_i | input | 1 | Start one frame (taken only in idle) |
| cfg_sleep_i | input | 1 | 1 = auto-sleep mode, 0 = normal mode |
| cfg_int_ref_i | input | 1 | 1 = internal reference (long wake-up), 0 = external |
| cfg_pair_en_i | input | 2 | Bit 0 enables pair A, bit 1 enables pair B |
| busy_i | input | 1 | Converter busy |
| adc_data_i | input | DATA_W | Converter parallel data bus |
| conv_n_o | output | 1 | Active-low conversion start strobe |
| chsel_o | output | 1 | Pair select (0 = A, 1 = B) |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read strobe |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_data_o | output | DATA_W | Captured result (two's complement for bipolar ranges) |
| res_tag_o | output | 2 | {pair, input} of the result |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |
| timeout_err_o | output | 1 | Busy timeout seen in the last frame |

## Verification
The assertions check the following on every cycle:
- no read pulse is low while busy is high;
- read pulses occur only inside chip-select;
- channel select never moves while the strobe is low;
- result-valid coincides with a rising read line;
- frame-done lasts one cycle;
- chip-select stays inactive while the error flag is set.

Some behaviours can only be shown by the bench scenarios, which sweep mode, pair enables and conversion length against a converter model:
- results come out in the right order, with the right tags and data;
- the settle, quiet and wake-up gaps are long enough;
- each chip-select window holds exactly two reads;
- timeout handling and clearing of the error flag work;
- a request that arrives during a frame is ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RISE  = 3'd1,
        S_SETUP = 3'd2,
        S_FALL  = 3'd3,
        S_CONV  = 3'd4,
        S_RD_LO = 3'd5,
        S_RD_HI = 3'd6
    } seq_state_e;

    // Nanoseconds to clock cycles, rounded up.
    function automatic int cyc_ceil(longint ns, longint cyc_per_us);
        return int'((ns * cyc_per_us + 64'd999) / 64'd1000);
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [DATA_W-1:0] data_in,
    input  logic [1:0]        tag_in,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic [1:0]        tag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            tag_o   <= '0;
        end else begin
            valid_o <= strobe;
            if (strobe) begin
                data_o <= data_in;
                tag_o  <= tag_in;
            end
        end
    end
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W       = 14,
    parameter int CYC_PER_US   = 100,
    parameter int RD_LO_CYC    = 2,
    parameter int RD_HI_CYC    = 2,
    parameter int START_LO_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_req_i,
    input  logic              cfg_sleep_i,
    input  logic              cfg_int_ref_i,
    input  logic [1:0]        cfg_pair_en_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              conv_n_o,
    output logic              chsel_o,
    output logic              cs_n_o,
    output logic              rd_n_o,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic [1:0]        res_tag_o,
    output logic              frame_done_o,
    output logic              timeout_err_o
);
    localparam int T_CONV     = cyc_ceil(5200, CYC_PER_US);
    localparam int T_TIMEOUT  = 2 * T_CONV;
    localparam int T_QUIET    = cyc_ceil(400, CYC_PER_US);
    localparam int T_SETTLE   = cyc_ceil(500, CYC_PER_US);
    localparam int T_WAKE_EXT = cyc_ceil(4800, CYC_PER_US);
    localparam int T_WAKE_INT = cyc_ceil(5000000, CYC_PER_US);
    localparam int T_GAP      = imax(T_SETTLE, T_QUIET);
    localparam int T_LONGEST  = imax(imax(T_WAKE_INT, T_TIMEOUT), T_GAP);
    localparam int CNT_W      = $clog2(T_LONGEST + 1) + 1;

    localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'(T_GAP - 1);
    localparam logic [CNT_W-1:0] LD_WEXT  = CNT_W'(imax(T_WAKE_EXT, T_GAP) - 1);
    localparam logic [CNT_W-1:0] LD_WINT  = CNT_W'(imax(T_WAKE_INT, T_GAP) - 1);
    localparam logic [CNT_W-1:0] LD_START = CNT_W'(START_LO_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TO    = CNT_W'(T_TIMEOUT - 1);
    localparam logic [CNT_W-1:0] LD_RDLO  = CNT_W'(RD_LO_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RDHI  = CNT_W'(RD_HI_CYC - 1);

    seq_state_e       state_q, state_d;
    logic             pair_q, pair_d;
    logic             rd_idx_q, rd_idx_d;
    logic             sleep_q, int_ref_q;
    logic [1:0]       en_q;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic             accept, timeout_hit, done_d, capture;

    adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    adc_seq_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (capture),
        .data_in (adc_data_i),
        .tag_in  ({pair_q, rd_idx_q}),
        .valid_o (res_valid_o),
        .data_o  (res_data_o),
        .tag_o   (res_tag_o)
    );

    // Next-state logic
    always_comb begin
        state_d     = state_q;
        pair_d      = pair_q;
        rd_idx_d    = rd_idx_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        accept      = 1'b0;
        timeout_hit = 1'b0;
        done_d      = 1'b0;
        capture     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (frame_req_i && (cfg_pair_en_i != 2'b00)) begin
                    accept  = 1'b1;
                    pair_d  = ~cfg_pair_en_i[0];
                    state_d = S_RISE;
                end
            end
            S_RISE: begin
                state_d  = S_SETUP;
                tmr_load = 1'b1;
                if (!sleep_q)
                    tmr_val = LD_GAP;
                else if (int_ref_q)
                    tmr_val = LD_WINT;
                else
                    tmr_val = LD_WEXT;
            end
            S_SETUP: begin
                if (tmr_zero) begin
                    state_d  = S_FALL;
                    tmr_load = 1'b1;
                    tmr_val  = LD_START;
                end
            end
            S_FALL: begin
                if (tmr_zero) begin
                    state_d  = S_CONV;
                    tmr_load = 1'b1;
                    tmr_val  = LD_TO;
                end
            end
            S_CONV: begin
                if (!busy_i) begin
                    state_d  = S_RD_LO;
                    rd_idx_d = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RDLO;
                end else if (tmr_zero) begin
                    state_d     = S_IDLE;
                    timeout_hit = 1'b1;
                end
            end
            S_RD_LO: begin
                if (tmr_zero) begin
                    state_d  = S_RD_HI;
                    capture  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RDHI;
                end
            end
            S_RD_HI: begin
                if (tmr_zero) begin
                    if (!rd_idx_q) begin
                        state_d  = S_RD_LO;
                        rd_idx_d = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = LD_RDLO;
                    end else if (!pair_q && en_q[1]) begin
                        state_d = S_RISE;
                        pair_d  = 1'b1;
                    end else begin
                        state_d = S_IDLE;
                        done_d  = 1'b1;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            pair_q    <= 1'b0;
            rd_idx_q  <= 1'b0;
            sleep_q   <= 1'b0;
            int_ref_q <= 1'b0;
            en_q      <= 2'b00;
        end else begin
            state_q  <= state_d;
            pair_q   <= pair_d;
            rd_idx_q <= rd_idx_d;
            if (accept) begin
                sleep_q   <= cfg_sleep_i;
                int_ref_q <= cfg_int_ref_i;
                en_q      <= cfg_pair_en_i;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_n_o      <= 1'b1;
            chsel_o       <= 1'b0;
            cs_n_o        <= 1'b1;
            rd_n_o        <= 1'b1;
            frame_done_o  <= 1'b0;
            timeout_err_o <= 1'b0;
        end else begin
            frame_done_o <= done_d;
            if (accept)
                timeout_err_o <= 1'b0;
            else if (timeout_hit)
                timeout_err_o <= 1'b1;
            if (state_d == S_RISE)
                conv_n_o <= 1'b1;
            else if (state_d == S_FALL)
                conv_n_o <= 1'b0;
            else if (state_q == S_FALL && !sleep_q)
                conv_n_o <= 1'b1;
            if (state_q == S_RISE)
                chsel_o <= pair_q;
            cs_n_o <= !((state_d == S_RD_LO) || (state_d == S_RD_HI));
            rd_n_o <= !(state_d == S_RD_LO);
        end
    end

    // R4: never a low read strobe while the converter is busy
    p_no_read_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !busy_i);

    // R5: read pulses only inside chip-select
    p_rd_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !cs_n_o);

    // R3: channel select moves only while the strobe is high
    p_chsel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chsel_o) |-> (conv_n_o && $past(conv_n_o)));

    // R6: a result coincides with the rising read line
    p_valid_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $rose(rd_n_o));

    // R10: frame done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    // R9: after a timeout the bus stays deselected
    p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err_o |-> cs_n_o);
endmodule

// File: tb/tb_adc_frame_seq.sv
module tb_adc_frame_seq;
    localparam int CPU = 10;
    localparam int DW  = 14;
    localparam int RLO = 2;
    localparam int RHI = 2;
    localparam int SLO = 2;
    // Expected cycle counts, ceil(ns*CPU/1000)
    localparam int E_SETTLE = (500 * CPU + 999) / 1000;
    localparam int E_QUIET  = (400 * CPU + 999) / 1000;
    localparam int E_WEXT   = (4800 * CPU + 999) / 1000;
    localparam int E_WINT   = (5000000 * CPU + 999) / 1000;
    localparam int E_TO     = 2 * ((5200 * CPU + 999) / 1000);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          frame_req = 1'b0;
    logic          cfg_sleep = 1'b0, cfg_int = 1'b0;
    logic [1:0]    cfg_en = 2'b00;
    logic          busy_m = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic          conv_n_o, chsel_o, cs_n_o, rd_n_o, res_valid_o, frame_done_o, timeout_err_o;
    logic [DW-1:0] res_data_o;
    logic [1:0]    res_tag_o;

    adc_frame_seq #(.DATA_W(DW), .CYC_PER_US(CPU), .RD_LO_CYC(RLO),
                    .RD_HI_CYC(RHI), .START_LO_CYC(SLO)) dut (
        .clk(clk), .rst_n(rst_n), .frame_req_i(frame_req), .cfg_sleep_i(cfg_sleep),
        .cfg_int_ref_i(cfg_int), .cfg_pair_en_i(cfg_en), .busy_i(busy_m),
        .adc_data_i(adc_data), .conv_n_o(conv_n_o), .chsel_o(chsel_o),
        .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .res_valid_o(res_valid_o),
        .res_data_o(res_data_o), .res_tag_o(res_tag_o),
        .frame_done_o(frame_done_o), .timeout_err_o(timeout_err_o));

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fdat(int k, int p, int i);
        return DW'((k * 211 + p * 37 + i * 19 + 5) % 16384);
    endfunction

    // Converter model and timing monitor state
    int conv_time = 10, bcnt = 0, conv_k = 0, lat_k = 0, lat_p = 0, rd_idx_m = 0;
    int since_chsel = 1000000, since_cs = 1000000, since_rise = 1000000;
    int rd_lo_len = 0, rd_hi_len = 0, rd_pulses = 0;
    int falls_cnt = 0, done_cnt = 0, n_got = 0;
    bit cur_sleep = 0, cur_int = 0;
    logic prev_conv = 1'b1, prev_chsel = 1'b0, prev_cs = 1'b1, prev_rd = 1'b1;
    logic [1:0]    got_tag [8];
    logic [DW-1:0] got_data[8];

    always @(negedge clk) begin
        if (rst_n) begin
            logic busy_old;
            busy_old = busy_m;
            since_chsel++; since_cs++; since_rise++;
            if (prev_rd == 1'b0) rd_lo_len++; else rd_hi_len++;
            if (prev_conv && !conv_n_o) begin
                falls_cnt++;
                chk(since_chsel >= E_SETTLE, "R3", "select settle cycles", since_chsel, E_SETTLE);
                chk(since_cs >= E_QUIET, "R3", "quiet cycles after read", since_cs, E_QUIET);
                if (cur_sleep)
                    chk(since_rise >= (cur_int ? E_WINT : E_WEXT), "R8", "wake-up cycles",
                        since_rise, cur_int ? E_WINT : E_WEXT);
                busy_m = 1'b1; bcnt = conv_time; conv_k++; lat_k = conv_k; lat_p = int'(chsel_o);
            end else if (busy_m) begin
                bcnt--;
                if (bcnt <= 0) busy_m = 1'b0;
            end
            if (!prev_conv && conv_n_o) since_rise = 0;
            if (chsel_o != prev_chsel) begin
                chk(conv_n_o && prev_conv, "R3", "select moved with strobe low", int'(conv_n_o), 1);
                since_chsel = 0;
            end
            if (prev_cs && !cs_n_o) begin rd_pulses = 0; rd_idx_m = 0; end
            if (!prev_cs && cs_n_o) begin
                chk(rd_pulses == 2, "R5", "reads per select", rd_pulses, 2);
                since_cs = 0;
            end
            if (prev_rd && !rd_n_o) begin
                rd_pulses++;
                chk(!busy_old && !cs_n_o, "R4", "read start while busy or deselected", int'(busy_old), 0);
                if (rd_pulses == 2) chk(rd_hi_len >= RHI, "R5", "read high cycles", rd_hi_len, RHI);
                rd_lo_len = 0;
            end
            if (!prev_rd && rd_n_o) begin
                chk(rd_lo_len >= RLO, "R5", "read low cycles", rd_lo_len, RLO);
                rd_idx_m = 1; rd_hi_len = 0;
            end
            adc_data = (!cs_n_o && !rd_n_o) ? fdat(lat_k, lat_p, rd_idx_m) : DW'(14'h1555);
            if (res_valid_o) begin
                if (n_got < 8) begin got_tag[n_got] = res_tag_o; got_data[n_got] = res_data_o; end
                n_got++;
            end
            if (frame_done_o) done_cnt++;
            prev_conv = conv_n_o; prev_chsel = chsel_o; prev_cs = cs_n_o; prev_rd = rd_n_o;
        end
    end

    task automatic run_frame(bit sl, bit ir, logic [1:0] en, int ctime, bit dup);
        int d0, k0, f0, np, idx, kk;
        @(negedge clk);
        n_got = 0; d0 = done_cnt; k0 = conv_k; f0 = falls_cnt;
        conv_time = ctime; cur_sleep = sl; cur_int = ir;
        cfg_sleep = sl; cfg_int = ir; cfg_en = en;
        frame_req = 1'b1;
        @(negedge clk) frame_req = 1'b0;
        if (dup) begin   // R11 stimulus: second request mid-frame
            repeat (20) @(negedge clk);
            frame_req = 1'b1;
            @(negedge clk) frame_req = 1'b0;
        end
        for (int w = 0; w < 120000 && done_cnt == d0; w++) @(negedge clk);
        repeat (200) @(negedge clk);
        np = int'(en[0]) + int'(en[1]);
        chk(done_cnt == d0 + 1, "R10", "frame done pulses", done_cnt - d0, 1);
        chk(falls_cnt == f0 + np, "R11", "conversions started", falls_cnt - f0, np);
        chk(n_got == 2 * np, "R2", "results per frame", n_got, 2 * np);
        idx = 0; kk = 0;
        for (int p = 0; p < 2; p++) begin
            if (en[p]) begin
                kk++;
                for (int i = 0; i < 2; i++) begin
                    if (idx < n_got && idx < 8) begin
                        chk(got_tag[idx] == 2'(p * 2 + i), "R6", "result tag",
                            int'(got_tag[idx]), p * 2 + i);
                        chk(got_data[idx] == fdat(k0 + kk, p, i), "R6", "result data",
                            int'(got_data[idx]), int'(fdat(k0 + kk, p, i)));
                    end
                    idx++;
                end
            end
        end
        if (sl) chk(conv_n_o == 1'b0, "R8", "strobe left low after frame", int'(conv_n_o), 0);
        else    chk(conv_n_o == 1'b1, "R7", "strobe high after frame", int'(conv_n_o), 1);
        chk(timeout_err_o == 1'b0, "R9", "error flag after good frame", int'(timeout_err_o), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int f0, d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(conv_n_o == 1'b1, "R1", "strobe at reset", int'(conv_n_o), 1);
        chk(cs_n_o == 1'b1 && rd_n_o == 1'b1, "R1", "select/read at reset", int'({cs_n_o, rd_n_o}), 3);
        chk(chsel_o == 1'b0, "R1", "pair select at reset", int'(chsel_o), 0);
        chk(!res_valid_o && !frame_done_o && !timeout_err_o, "R1", "flags at reset",
            int'({res_valid_o, frame_done_o, timeout_err_o}), 0);

        // Sweep: mode x pair enables x conversion length (R2 R6 R7 R8 R11)
        for (int sl = 0; sl < 2; sl++)
            for (int en = 1; en < 4; en++)
                for (int ct = 0; ct < 2; ct++)
                    run_frame(bit'(sl), 1'b0, 2'(en), ct ? 45 : 3, bit'(ct));

        // R8: internal reference, long wake-up, pair B only
        run_frame(1'b1, 1'b1, 2'b10, 20, 1'b0);

        // R2: both pairs disabled starts nothing
        @(negedge clk);
        f0 = falls_cnt; d0 = done_cnt; n_got = 0;
        cfg_en = 2'b00; cfg_sleep = 1'b0; cur_sleep = 0;
        frame_req = 1'b1;
        @(negedge clk) frame_req = 1'b0;
        repeat (100) @(negedge clk);
        chk(falls_cnt == f0 && done_cnt == d0 && n_got == 0, "R2", "activity with no pair enabled",
            falls_cnt - f0 + done_cnt - d0 + n_got, 0);

        // R9: busy longer than the timeout
        conv_time = 400; cfg_en = 2'b01; cur_int = 0; d0 = done_cnt;
        frame_req = 1'b1;
        @(negedge clk) frame_req = 1'b0;
        repeat (50) @(negedge clk);
        chk(timeout_err_o == 1'b0, "R9", "error flag before timeout", int'(timeout_err_o), 0);
        repeat (250) @(negedge clk);
        chk(timeout_err_o == 1'b1, "R9", "error flag after timeout", int'(timeout_err_o), 1);
        chk(n_got == 0 && done_cnt == d0, "R9", "reads or done after timeout", n_got + done_cnt - d0, 0);
        repeat (300) @(negedge clk);
        // next frame clears the flag (checked inside run_frame)
        run_frame(1'b0, 1'b0, 2'b11, 10, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule